// File: doc/BRIEF.md
# UART Interrupt Identification and Priority Logic

This block sits inside a 16550-style serial port and decides what the interrupt identification register shows and whether the interrupt request line is raised. It tracks three pending sources: a line-status error, receive data at or above the FIFO trigger level, and an empty transmit holding register. Each pending source is gated by its enable bit. Of the enabled pending sources, only the most urgent one is presented.

The receiver and transmitter pulse single-cycle event strobes into the block. The receive source instead follows a level from the receive FIFO. The bus side gives a read strobe with a register address. A read at the line-status address retires the line-status source. A read at the identification address retires the transmit-empty source, but only when that source is the one being presented.

A transmit-empty event that lands in the same cycle as a retiring read is never lost. Setting takes precedence over clearing in every pending flag.

Top module: `uart_int_ident`

## Requirements
- R1: Fixed priority from highest to lowest is line status, then receive data, then transmit empty. Bits 3:1 of the identification value are 011, 010 or 001 for those sources. Bit 0 is 1 exactly when no enabled source is pending, in which case bits 3:1 are 000. Bits 5:4 always read 0.
- R2: A pending source whose enable bit is 0 is neither presented nor counted in the request. It stays pending, and it is presented as soon as its enable bit is set.
- R3: When the presented source is cleared while another enabled source is pending, the request stays high and the next source in priority order is presented from the following cycle.
- R4: A line-status strobe sets its flag at the next clock edge. A read at the line-status address (address 5) clears it, unless a strobe arrives in the same cycle.
- R5: The receive-data flag equals the receive-at-trigger level sampled at the previous clock edge.
- R6: A transmit-empty strobe sets its flag. A read at the identification address (address 2) clears it only if transmit empty was the presented source on that read. The flag never re-asserts by itself.
- R7: If a transmit-empty strobe and a read that would clear that flag occur in the same cycle, the flag stays set.
- R8: The request output is a register. After each clock edge it equals the OR of all pending sources whose enables were set in the cycle before that edge.
- R9: Bits 7:6 of the identification value read 11 when the FIFO enable input is 1, and 00 when it is 0.
- R10: After reset no source is pending, the request is 0, and the identification value is 0x01 with the FIFO enable at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fifo_en_i | input | 1 | FIFO enable bit from the FIFO control register |
| src_en_i | input | 3 | Enables: bit 0 line status, bit 1 receive, bit 2 transmit empty |
| ls_err_set_i | input | 1 | Line-status error event strobe |
| rx_at_trig_i | input | 1 | Receive FIFO at or above trigger level |
| tx_empty_set_i | input | 1 | Transmit holding register empty event strobe |
| rd_stb_i | input | 1 | Register read strobe |
| rd_addr_i | input | 3 | Register address of the read |
| iid_o | output | 8 | Identification register value |
| irq_o | output | 1 | Interrupt request |

## Verification
A wrong pending flag becomes visible in the identification value in the first cycle after the clock edge that stored it. A wrong request reaches the port in the same cycle.

A lost transmit-empty flag is the most dangerous failure, because nothing ever restores it. The bench therefore checks the identification value right after the collision read, and again after a read where another source was presented.

Sweeping every combination of pending sources, enables and FIFO enable exposes any priority or masking error in a single cycle.

// File: rtl/uart_iid_pkg.sv
package uart_iid_pkg;
  localparam int NSRC   = 3;
  localparam int SRC_LS = 0;
  localparam int SRC_RX = 1;
  localparam int SRC_TX = 2;

  typedef logic [2:0] id_code_t;

  function automatic id_code_t code_of(int idx);
    case (idx)
      SRC_LS:  return 3'b011;
      SRC_RX:  return 3'b010;
      SRC_TX:  return 3'b001;
      default: return 3'b000;
    endcase
  endfunction
endpackage

// File: rtl/uart_iid_flag.sv
module uart_iid_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic pend_o,
  output logic pend_nxt_o
);
  logic pend_q;

  always_comb begin
    pend_nxt_o = set_i | (pend_q & ~clr_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= 1'b0;
    else        pend_q <= pend_nxt_o;
  end

  assign pend_o = pend_q;

  // R7: a set in the same cycle as a clear is kept
  p_set_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> pend_o);
endmodule

// File: rtl/uart_iid_prio.sv
module uart_iid_prio #(
  parameter int N = 3
) (
  input  logic [N-1:0] req_i,
  output logic [N-1:0] gnt_o,
  output logic         any_o
);
  logic [N:0] seen;
  assign seen[0] = 1'b0;

  for (genvar i = 0; i < N; i++) begin : g_chain
    assign gnt_o[i]    = req_i[i] & ~seen[i];
    assign seen[i + 1] = seen[i] | req_i[i];
  end

  assign any_o = seen[N];

  always_comb begin
    p_grant_onehot_r1: assert ($onehot0(gnt_o));
  end
endmodule

// File: rtl/uart_int_ident.sv
module uart_int_ident
  import uart_iid_pkg::*;
#(
  parameter int              ADDR_W   = 3,
  parameter logic [ADDR_W-1:0] IID_ADDR = 3'd2,
  parameter logic [ADDR_W-1:0] LSR_ADDR = 3'd5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fifo_en_i,
  input  logic [NSRC-1:0]   src_en_i,
  input  logic              ls_err_set_i,
  input  logic              rx_at_trig_i,
  input  logic              tx_empty_set_i,
  input  logic              rd_stb_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [7:0]        iid_o,
  output logic              irq_o
);
  logic            iid_rd, lsr_rd;
  logic [NSRC-1:0] set_v, clr_v, pend, pend_nxt, active, gnt;
  logic            any_act;
  id_code_t        code;
  logic            irq_q, irq_d;

  assign iid_rd = rd_stb_i & (rd_addr_i == IID_ADDR);
  assign lsr_rd = rd_stb_i & (rd_addr_i == LSR_ADDR);

  always_comb begin
    set_v         = '0;
    clr_v         = '0;
    set_v[SRC_LS] = ls_err_set_i;
    clr_v[SRC_LS] = lsr_rd;
    set_v[SRC_RX] = rx_at_trig_i;
    clr_v[SRC_RX] = ~rx_at_trig_i;
    set_v[SRC_TX] = tx_empty_set_i;
    clr_v[SRC_TX] = iid_rd & gnt[SRC_TX];
  end

  for (genvar i = 0; i < NSRC; i++) begin : g_src
    uart_iid_flag u_flag (
      .clk       (clk),
      .rst_n     (rst_n),
      .set_i     (set_v[i]),
      .clr_i     (clr_v[i]),
      .pend_o    (pend[i]),
      .pend_nxt_o(pend_nxt[i])
    );
  end

  assign active = pend & src_en_i;

  uart_iid_prio #(.N(NSRC)) u_prio (
    .req_i(active),
    .gnt_o(gnt),
    .any_o(any_act)
  );

  always_comb begin
    code = '0;
    for (int i = 0; i < NSRC; i++) begin
      if (gnt[i]) code = code | code_of(i);
    end
  end

  assign iid_o = {{2{fifo_en_i}}, 2'b00, code, ~any_act};

  assign irq_d = |(pend_nxt & src_en_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= irq_d;
  end

  assign irq_o = irq_q;

  // R8: with stable enables the request agrees with the identification value
  p_irq_tracks_id_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $stable(src_en_i) |-> (irq_o == !iid_o[0]));

  // R6: a read that returned another source leaves transmit empty pending
  p_tx_survives_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (iid_rd && pend[SRC_TX] && !gnt[SRC_TX]) |=> pend[SRC_TX]);

  // R4: a line-status read with no new event clears the source
  p_ls_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (lsr_rd && !ls_err_set_i) |=> !pend[SRC_LS]);

  // R5: the receive source follows the trigger level one cycle later
  p_rx_follow_r5: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (pend[SRC_RX] == $past(rx_at_trig_i)));
endmodule

// File: tb/uart_int_ident_bench.sv
`timescale 1ns/1ps
module uart_int_ident_bench;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       fifo_en;
  logic [2:0] src_en;
  logic       ls_set, rx_lvl, tx_set, rd_stb;
  logic [2:0] rd_addr;
  logic [7:0] iid;
  logic       irq;
  int         checks = 0;
  int         fails = 0;
  bit         done = 1'b0;

  always #2.5 clk = ~clk;

  uart_int_ident u_uart_int_ident (
    .clk(clk), .rst_n(rst_n), .fifo_en_i(fifo_en), .src_en_i(src_en),
    .ls_err_set_i(ls_set), .rx_at_trig_i(rx_lvl), .tx_empty_set_i(tx_set),
    .rd_stb_i(rd_stb), .rd_addr_i(rd_addr), .iid_o(iid), .irq_o(irq)
  );

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; ls_set = 0; rx_lvl = 0; tx_set = 0; rd_stb = 0; rd_addr = 0;
    tick(); tick();
    rst_n = 1'b1;
    tick();
  endtask

  function automatic logic [7:0] exp_iid(logic [2:0] p, logic [2:0] e, logic f);
    logic [2:0] a = p & e;
    logic [2:0] c;
    if (a[0])      c = 3'b011;
    else if (a[1]) c = 3'b010;
    else if (a[2]) c = 3'b001;
    else           c = 3'b000;
    return {f, f, 2'b00, c, (a == 3'b000)};
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    fifo_en = 0; src_en = 3'b111;
    do_reset();
    chk("R10 reset iid", iid, 8'h01);
    chk("R10 reset irq", {7'd0, irq}, 8'h00);

    // Sweep: R1 R2 R8 R9
    for (int f = 0; f < 2; f++) begin
      for (int p = 0; p < 8; p++) begin
        for (int e = 0; e < 8; e++) begin
          do_reset();
          fifo_en = f[0]; src_en = e[2:0];
          ls_set = p[0]; rx_lvl = p[1]; tx_set = p[2];
          tick();
          ls_set = 0; tx_set = 0;
          tick();
          chk("R1 R2 R9 sweep iid", iid, exp_iid(p[2:0], e[2:0], f[0]));
          chk("R8 sweep irq", {7'd0, irq}, {7'd0, |(p[2:0] & e[2:0])});
        end
      end
    end

    fifo_en = 1; src_en = 3'b111;
    // R3: service in priority order
    do_reset();
    ls_set = 1; rx_lvl = 1; tx_set = 1; tick();
    ls_set = 0; tx_set = 0;
    chk("R3 all pending", iid, 8'hC6);
    rd_stb = 1; rd_addr = 3'd5; tick(); rd_stb = 0;
    chk("R3 after lsr read", iid, 8'hC4);
    chk("R3 irq held", {7'd0, irq}, 8'h01);
    rx_lvl = 0; tick();
    chk("R3 after rx drop", iid, 8'hC2);
    rd_stb = 1; rd_addr = 3'd2;
    chk("R6 read returns tx", iid, 8'hC2);
    tick(); rd_stb = 0;
    chk("R6 tx cleared", iid, 8'hC1);
    chk("R8 irq low", {7'd0, irq}, 8'h00);
    tick(); tick();
    chk("R6 no re-assert", iid, 8'hC1);

    // R6: read while RX presented keeps TX
    do_reset();
    tx_set = 1; rx_lvl = 1; tick(); tx_set = 0;
    chk("R6 rx over tx", iid, 8'hC4);
    rd_stb = 1; rd_addr = 3'd2; tick(); rd_stb = 0;
    rx_lvl = 0; tick();
    chk("R6 tx survived", iid, 8'hC2);

    // R7: collision of set and clearing read
    do_reset();
    tx_set = 1; tick(); tx_set = 0;
    chk("R7 tx pending", iid, 8'hC2);
    rd_stb = 1; rd_addr = 3'd2; tx_set = 1; tick(); rd_stb = 0; tx_set = 0;
    chk("R7 set wins", iid, 8'hC2);
    chk("R7 irq kept", {7'd0, irq}, 8'h01);
    rd_stb = 1; tick(); rd_stb = 0;
    chk("R7 later clear", iid, 8'hC1);

    // R4: line status set wins, then read clears
    do_reset();
    ls_set = 1; tick();
    rd_stb = 1; rd_addr = 3'd5; tick(); ls_set = 0;
    chk("R4 set wins", iid, 8'hC6);
    tick(); rd_stb = 0;
    chk("R4 cleared", iid, 8'hC1);

    // R2: masked TX kept, appears when enabled
    do_reset();
    src_en = 3'b000; tx_set = 1; tick(); tx_set = 0;
    chk("R2 masked", iid, 8'hC1);
    chk("R2 masked irq", {7'd0, irq}, 8'h00);
    rd_stb = 1; rd_addr = 3'd2; tick(); rd_stb = 0;
    src_en = 3'b100; tick();
    chk("R2 unmasked", iid, 8'hC2);
    chk("R2 irq", {7'd0, irq}, 8'h01);

    // R5: receive level timing
    do_reset();
    src_en = 3'b111; rx_lvl = 1; #1;
    chk("R5 before edge", iid, 8'hC1);
    tick();
    chk("R5 after edge", iid, 8'hC4);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule